// File: doc/BRIEF.md
# Configurable Bidirectional I/O Port

This block is one general-purpose I/O port of a small controller. Software sees three byte-wide locations: a configuration register, a data register and a read-only view of the pins. For each pin, the pair formed by its configuration bit and its data bit selects one of four modes: floating input, input with a weak pull-up, driven low or driven high. The block drives per-pin output-enable, output-value and pull-up-enable signals toward the pads. It passes the pad inputs through a two-flop synchronizer before they can be read back.

A parameter turns the port into a control port. In that variant the two top data bits are not stored. Writing a 1 to either of them fires a one-cycle request to enter a stop or a sleep power mode, and both bits always read back as zero. The two top configuration bits are stored and routed out as an alternate serial-clock phase select and a clock start-up delay enable. The pins behind those two bits are never driven or pulled by the port.

Top module: `cfg_io_port`

## Requirements
- R1: After a synchronous reset the configuration and data registers read 0x00, so every pin has output enable 0 and pull-up 0. The power-mode requests and the two control outputs are low.
- R2: For each pin the 2-bit code {config, data} selects the mode: 00 floating input (oe=0, pu=0), 01 pull-up input (oe=0, pu=1), 10 drive low (oe=1, out=0), 11 drive high (oe=1, out=1). The pad outputs follow a register write from the clock edge that takes it.
- R3: Register addresses are 0 configuration, 1 data and 2 synchronized pins; address 3 reads 0x00. The read data follow the address without a clock. A write with wr_en high is taken at the rising edge.
- R4: Writes to address 2 or 3 change neither register nor any pad output.
- R5: A pin level appears on the pin register (address 2) after exactly two rising edges, and not after one.
- R6: In the control variant, a write to address 1 with bit 7 set raises halt_req, and one with bit 6 set raises idle_req. Each request is high for exactly the one cycle after the write edge. A write with the bit clear raises nothing.
- R7: In the control variant, data bits 7 and 6 always read as 0, while data bits 5..0 read back what was written.
- R8: In the control variant, configuration bit 6 drives alt_clk_phase and configuration bit 7 drives start_delay_en; both read back. Pins 7 and 6 keep oe=0 and pu=0 whatever the registers hold.
- R9: In the general variant, all eight bits of both registers are stored and read back, and all eight pins follow R2. halt_req, idle_req, alt_clk_phase and start_delay_en stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken at the rising edge |
| addr | input | 2 | Register select: 0 config, 1 data, 2 pins, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Asynchronous pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| halt_req | output | 1 | One-cycle stop-mode request (control variant) |
| idle_req | output | 1 | One-cycle sleep-mode request (control variant) |
| alt_clk_phase | output | 1 | Alternate serial clock phase select (control variant) |
| start_delay_en | output | 1 | Clock start-up delay enable after stop (control variant) |

## Verification
A corrupted configuration or data bit shows on pad_oe, pad_out or pad_pu, and on the register readback, in the cycle right after the write edge. Each mode pattern is therefore checked one cycle after its write. A stuck or missing synchronizer stage shows as the pin register changing one cycle early or late, so the pin register is sampled after one edge and after two. A strobe bit that is wrongly stored shows as a nonzero readback of data bits 7..6, or as a request that lasts longer than one cycle.

// File: rtl/gpio_port_pkg.sv
// Shared types for the configurable I/O port: register select codes,
// pin mode codes and the per-pin pad control bundle.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_DAT  = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

    // {config bit, data bit}
    typedef enum logic [1:0] {
        MODE_FLOAT  = 2'b00,
        MODE_PULLUP = 2'b01,
        MODE_DRIVE0 = 2'b10,
        MODE_DRIVE1 = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic oe;
        logic val;
        logic pu;
    } pad_ctl_t;

    // Translate one pin's mode code into its pad controls.
    function automatic pad_ctl_t mode_to_pad(input pin_mode_e m);
        pad_ctl_t p;
        p = '0;
        case (m)
            MODE_FLOAT:  p = '{oe: 1'b0, val: 1'b0, pu: 1'b0};
            MODE_PULLUP: p = '{oe: 1'b0, val: 1'b0, pu: 1'b1};
            MODE_DRIVE0: p = '{oe: 1'b1, val: 1'b0, pu: 1'b0};
            MODE_DRIVE1: p = '{oe: 1'b1, val: 1'b1, pu: 1'b0};
            default:     p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/port_regs.sv
// Configuration and data registers of one port, plus the write-triggered
// power-mode strobes of the control variant.
// Assumes: synchronous active-low reset; one write per cycle at most.
module port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter bit CTRL_PORT = 1'b0,
    parameter int HALT_BIT  = WIDTH - 1,
    parameter int IDLE_BIT  = WIDTH - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] cfg_q,
    output logic [WIDTH-1:0] dat_q,
    output logic             halt_req,
    output logic             idle_req
);

    logic wr_cfg;
    logic wr_dat;

    // Decode which register a write targets.
    always_comb begin
        wr_cfg = wr_en && (port_sel_e'(addr) == SEL_CFG);
        wr_dat = wr_en && (port_sel_e'(addr) == SEL_DAT);
    end

    // Configuration register: every bit stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= wdata;
    end

    // Data register: strobe bits of the control variant hold no state.
    for (genvar i = 0; i < WIDTH; i++) begin : g_dat
        if (CTRL_PORT && (i == HALT_BIT || i == IDLE_BIT)) begin : g_strobe_bit
            assign dat_q[i] = 1'b0;
        end else begin : g_store_bit
            logic bit_q;
            // Hold one stored data bit.
            always_ff @(posedge clk) begin
                if (!rst_n)      bit_q <= 1'b0;
                else if (wr_dat) bit_q <= wdata[i];
            end
            assign dat_q[i] = bit_q;
        end
    end

    if (CTRL_PORT) begin : g_strobes
        // Turn a data write with a strobe bit set into a one-cycle request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                halt_req <= 1'b0;
                idle_req <= 1'b0;
            end else begin
                halt_req <= wr_dat && wdata[HALT_BIT];
                idle_req <= wr_dat && wdata[IDLE_BIT];
            end
        end

        // R6
        halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && halt_req) |->
                $past(wr_en && addr == 2'd1 && wdata[HALT_BIT]));

        // R6
        idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && idle_req) |->
                $past(wr_en && addr == 2'd1 && wdata[IDLE_BIT]));
    end else begin : g_no_strobes
        assign halt_req = 1'b0;
        assign idle_req = 1'b0;
    end

    // R4
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1]) |=> ($stable(cfg_q) && $stable(dat_q)));

endmodule

// File: rtl/pad_decode.sv
// Per-pin mode decoder: maps {config, data} to output enable, output value
// and pull-up enable. In the control variant the two reserved top pins
// are held as plain floating inputs.
module pad_decode
    import gpio_port_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter bit CTRL_PORT = 1'b0,
    parameter int RSV_LO    = WIDTH - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cfg_q,
    input  logic [WIDTH-1:0] dat_q,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (CTRL_PORT && i >= RSV_LO) begin : g_reserved
            assign pad_oe[i]  = 1'b0;
            assign pad_out[i] = 1'b0;
            assign pad_pu[i]  = 1'b0;
        end else begin : g_general
            pad_ctl_t ctl;
            // Decode this pin's mode code.
            always_comb ctl = mode_to_pad(pin_mode_e'({cfg_q[i], dat_q[i]}));
            assign pad_oe[i]  = ctl.oe;
            assign pad_out[i] = ctl.val;
            assign pad_pu[i]  = ctl.pu;
        end
    end

    // R2
    pull_drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0);

endmodule

// File: rtl/pin_sync.sv
// Multi-stage synchronizer carrying the asynchronous pad levels into the
// clock domain before they reach the pin register.
// Assumes: STAGES >= 1; inputs may change at any time.
module pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= pin_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign pin_q = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_io_port.sv
// Top of the configurable I/O port: register file, pad mode decoding,
// input synchronizer and the read multiplexer.
// Assumes: synchronous active-low reset; WIDTH >= 3 when CTRL_PORT is set.
module cfg_io_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit CTRL_PORT   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu,
    output logic             halt_req,
    output logic             idle_req,
    output logic             alt_clk_phase,
    output logic             start_delay_en
);

    localparam int HALT_BIT = WIDTH - 1;
    localparam int IDLE_BIT = WIDTH - 2;

    logic [WIDTH-1:0] cfg_q;
    logic [WIDTH-1:0] dat_q;
    logic [WIDTH-1:0] pin_q;

    port_regs #(
        .WIDTH(WIDTH), .CTRL_PORT(CTRL_PORT),
        .HALT_BIT(HALT_BIT), .IDLE_BIT(IDLE_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cfg_q(cfg_q), .dat_q(dat_q), .halt_req(halt_req), .idle_req(idle_req)
    );

    pad_decode #(
        .WIDTH(WIDTH), .CTRL_PORT(CTRL_PORT), .RSV_LO(IDLE_BIT)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .dat_q(dat_q),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    pin_sync #(
        .WIDTH(WIDTH), .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_q(pin_q)
    );

    // Route the control bits of the configuration register.
    if (CTRL_PORT) begin : g_ctrl_out
        assign alt_clk_phase  = cfg_q[IDLE_BIT];
        assign start_delay_en = cfg_q[HALT_BIT];
    end else begin : g_no_ctrl_out
        assign alt_clk_phase  = 1'b0;
        assign start_delay_en = 1'b0;
    end

    // Select the register seen on the read port.
    always_comb begin
        case (port_sel_e'(addr))
            SEL_CFG: rdata = cfg_q;
            SEL_DAT: rdata = dat_q;
            SEL_PIN: rdata = pin_q;
            default: rdata = '0;
        endcase
    end

    if (SYNC_STAGES == 2) begin : g_sync_chk
        // R5
        pin_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2)) |-> (pin_q == $past(pin_in, 2)));
    end

endmodule

// File: tb/cfg_io_port_tb.sv
// Directed bench: one control-variant port (u_dut) and one general port
// (u_dut_gp) share the bus and pin inputs.
module cfg_io_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] pin_in = 8'h00;

    logic [7:0] rd_c, oe_c, out_c, pu_c;
    logic [7:0] rd_g, oe_g, out_g, pu_g;
    logic       halt_c, idle_c, alt_c, dly_c;
    logic       halt_g, idle_g, alt_g, dly_g;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    cfg_io_port #(.CTRL_PORT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rd_c), .pin_in(pin_in), .pad_oe(oe_c), .pad_out(out_c),
        .pad_pu(pu_c), .halt_req(halt_c), .idle_req(idle_c),
        .alt_clk_phase(alt_c), .start_delay_en(dly_c)
    );

    cfg_io_port #(.CTRL_PORT(1'b0)) u_dut_gp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rd_g), .pin_in(pin_in), .pad_oe(oe_g), .pad_out(out_g),
        .pad_pu(pu_g), .halt_req(halt_g), .idle_req(idle_g),
        .alt_clk_phase(alt_g), .start_delay_en(dly_g)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Write at a falling edge; returns at the next falling edge, after the write edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_sel(input logic [1:0] a);
        addr = a;
        #1;
    endtask

    // Expected pad outputs from R2; ctl masks the reserved pins (R8).
    function automatic logic [7:0] exp_oe(input logic [7:0] c, input bit ctl);
        return ctl ? (c & 8'h3F) : c;
    endfunction
    function automatic logic [7:0] exp_out(input logic [7:0] c, input logic [7:0] d, input bit ctl);
        return ctl ? (c & d & 8'h3F) : (c & d);
    endfunction
    function automatic logic [7:0] exp_pu(input logic [7:0] c, input logic [7:0] d, input bit ctl);
        return ctl ? (~c & d & 8'h3F) : (~c & d);
    endfunction

    task automatic t_reset();
        check("R1 ctl oe", oe_c, 8'h00);
        check("R1 ctl pu", pu_c, 8'h00);
        check("R1 gp oe", oe_g, 8'h00);
        check("R1 gp pu", pu_g, 8'h00);
        check("R1 strobes/ctl outs", {4'h0, halt_c, idle_c, alt_c, dly_c}, 8'h00);
        rd_sel(2'd0); check("R1 cfg read", rd_c, 8'h00);
        rd_sel(2'd1); check("R1 dat read", rd_g, 8'h00);
    endtask

    task automatic t_modes();
        logic [7:0] cs [4] = '{8'hF0, 8'h0F, 8'hAA, 8'hFF};
        logic [7:0] ds [4] = '{8'hCC, 8'h33, 8'h3C, 8'h5A};
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, cs[k]);
            wr(2'd1, ds[k]);
            check("R2 gp oe",  oe_g,  exp_oe(cs[k], 0));
            check("R2 gp out", out_g, exp_out(cs[k], ds[k], 0));
            check("R2 gp pu",  pu_g,  exp_pu(cs[k], ds[k], 0));
            check("R8 ctl oe",  oe_c,  exp_oe(cs[k], 1));
            check("R8 ctl out", out_c, exp_out(cs[k], ds[k], 1));
            check("R8 ctl pu",  pu_c,  exp_pu(cs[k], ds[k], 1));
        end
    endtask

    task automatic t_readback();
        wr(2'd0, 8'h96);
        wr(2'd1, 8'hE5);
        rd_sel(2'd0); check("R3 cfg read", rd_g, 8'h96);
        check("R8 ctl cfg read", rd_c, 8'h96);
        rd_sel(2'd1); check("R9 gp dat read", rd_g, 8'hE5);
        check("R7 ctl dat read", rd_c, 8'h25);
        rd_sel(2'd3); check("R3 addr3 read", rd_g, 8'h00);
        check("R3 addr3 read ctl", rd_c, 8'h00);
    endtask

    task automatic t_ignore();
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'h15);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd_sel(2'd0); check("R4 cfg kept", rd_g, 8'h3C);
        rd_sel(2'd1); check("R4 dat kept", rd_g, 8'h15);
        check("R4 oe kept", oe_g, 8'h3C);
        check("R4 pu kept", pu_g, 8'h01);
        check("R4 out kept", out_g, 8'h14);
    endtask

    task automatic t_sync();
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        rd_sel(2'd2);
        pin_in = 8'hA7;
        @(negedge clk); #1;
        check("R5 one edge", rd_c, 8'h00);
        @(negedge clk); #1;
        check("R5 two edges", rd_c, 8'hA7);
        check("R5 two edges gp", rd_g, 8'hA7);
        pin_in = 8'h5C;
        @(negedge clk); #1;
        check("R5 one edge b", rd_g, 8'hA7);
        @(negedge clk); #1;
        check("R5 two edges b", rd_g, 8'h5C);
    endtask

    task automatic t_strobes();
        wr_en = 1'b1; addr = 2'd1; wdata = 8'h80;
        @(negedge clk); wr_en = 1'b0;
        check("R6 halt pulse", {6'h0, halt_c, idle_c}, 8'h02);
        check("R9 gp no strobe", {6'h0, halt_g, idle_g}, 8'h00);
        @(negedge clk);
        check("R6 halt one cycle", {6'h0, halt_c, idle_c}, 8'h00);
        wr(2'd1, 8'h40);
        check("R6 idle pulse", {6'h0, halt_c, idle_c}, 8'h01);
        @(negedge clk);
        check("R6 idle one cycle", {6'h0, halt_c, idle_c}, 8'h00);
        wr(2'd1, 8'h3F);
        check("R6 no strobe on clear bits", {6'h0, halt_c, idle_c}, 8'h00);
        wr(2'd1, 8'hC1);
        check("R6 both strobes", {6'h0, halt_c, idle_c}, 8'h03);
        rd_sel(2'd1); check("R7 strobe bits read 0", rd_c, 8'h01);
        check("R9 gp keeps bits 7..6", rd_g, 8'hC1);
    endtask

    task automatic t_ctrl_cfg();
        wr(2'd0, 8'h40);
        check("R8 alt phase", {6'h0, alt_c, dly_c}, 8'h02);
        wr(2'd0, 8'h80);
        check("R8 start delay", {6'h0, alt_c, dly_c}, 8'h01);
        check("R9 gp ctl outs", {6'h0, alt_g, dly_g}, 8'h00);
        wr(2'd0, 8'hC0);
        wr(2'd1, 8'hC0);
        check("R8 reserved pins undriven", oe_c, 8'h00);
        check("R9 gp top pins driven", oe_g & out_g, 8'hC0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_readback();
        t_ignore();
        t_sync();
        t_strobes();
        t_ctrl_cfg();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule